// File: doc/BRIEF.md
# Multi-Channel Power-Good Reset Generator

This block turns per-channel regulation status into per-channel active-low reset outputs. Each channel has a status input that is high while its supply is in regulation and an enable input that says whether the channel is switched on and present in the current configuration. A shared tick strobe sets the time base. Both the fault filter and the release delay are counted in ticks.

A channel drives its reset low as soon as it is disabled. Once enabled, the channel keeps its reset low until the synchronised status has stayed high for `DLY_TICKS` consecutive ticks. It then releases the reset. A released channel asserts its reset again only after the status has been low for `FILT_TICKS` consecutive ticks, so a shorter dip has no effect. If the status goes low at any point during the release delay, the delay starts again from zero. Any difference in undervoltage thresholds between channels belongs to whatever drives the status inputs; the logic is the same for every channel.

Top module: `pgood_reset_gen`

## Requirements
- R1: After a synchronous reset, every bit of `rst_n_out` is 0, which means the reset is asserted.
- R2: A channel whose `ch_en` bit is 0 holds its `rst_n_out` bit at 0 whatever its status input does.
- R3: When `ch_en` falls, the channel's `rst_n_out` bit goes to 0 in the same cycle, with no filtering. After `ch_en` returns to 1, the channel must again complete the full release delay.
- R4: A channel in reset releases (`rst_n_out` = 1) only after its synchronised status has been high for `DLY_TICKS` consecutive tick strobes.
- R5: On a released channel, a status low that lasts fewer than `FILT_TICKS` ticks leaves `rst_n_out` at 1.
- R6: On a released channel, a status low that lasts `FILT_TICKS` ticks drives `rst_n_out` to 0.
- R7: Any status low during the release delay clears the delay count, and the full `DLY_TICKS` period must then elapse again.
- R8: The channels are independent: a fault or a disable on one channel does not change the outputs of the others.
- R9: Filter and delay counts advance only on cycles where `tick` is 1. Without ticks, no output changes except through `ch_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared time-base strobe, one cycle wide |
| ch_good | input | NUM_CH | Per-channel regulation status, asynchronous, 1 = in regulation |
| ch_en | input | NUM_CH | Per-channel enable/availability, 1 = enabled |
| rst_n_out | output | NUM_CH | Per-channel active-low reset, 0 = asserted |

## Verification
The bench builds the block with `FILT_TICKS` = 6 and `DLY_TICKS` = 40, and it pulses `tick` once every four clocks. With these values the release delay is about 160 cycles and the fault filter about 24 cycles. Every path, including the restart of the release delay, can therefore be reached in a few hundred cycles per scenario. The margins in the dip lengths and wait times allow for the synchroniser latency and for tick phase. Each check still separates a correct count from one that is off, or from one that is never cleared. Gating `tick` off in the bench makes the hold-without-ticks behaviour observable.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    typedef enum logic {
        CH_HOLD = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic en;
        logic good;
    } ch_in_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pgr_sync.sv
module pgr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pgr_channel.sv
module pgr_channel
    import pgr_pkg::*;
#(
    parameter int FILT_TICKS = 100,
    parameter int DLY_TICKS  = 2020,
    parameter int CW         = 12
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  ch_in_t cin,
    output logic   rst_n
);
    localparam logic [CW-1:0] FILT_LAST = CW'(FILT_TICKS - 1);
    localparam logic [CW-1:0] DLY_LAST  = CW'(DLY_TICKS - 1);

    ch_state_e       state, state_nxt;
    logic [CW-1:0]   cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (!cin.en) begin
            state_nxt = CH_HOLD;
            cnt_nxt   = '0;
        end else begin
            case (state)
                CH_HOLD: begin
                    if (!cin.good) begin
                        cnt_nxt = '0;
                    end else if (tick) begin
                        if (cnt == DLY_LAST) begin
                            state_nxt = CH_RUN;
                            cnt_nxt   = '0;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                end
                CH_RUN: begin
                    if (cin.good) begin
                        cnt_nxt = '0;
                    end else if (tick) begin
                        if (cnt == FILT_LAST) begin
                            state_nxt = CH_HOLD;
                            cnt_nxt   = '0;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state_nxt = CH_HOLD;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign rst_n = (state == CH_RUN) && cin.en;
endmodule

// File: rtl/pgood_reset_gen.sv
module pgood_reset_gen
    import pgr_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TICKS  = 100,
    parameter int DLY_TICKS   = 2020
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NUM_CH-1:0] ch_good,
    input  logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] rst_n_out
);
    localparam int MAX_TICKS = (FILT_TICKS > DLY_TICKS) ? FILT_TICKS : DLY_TICKS;
    localparam int CW        = cnt_bits(MAX_TICKS);

    logic [NUM_CH-1:0] good_s;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_in_t cin;

        pgr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (ch_good[i]),
            .q   (good_s[i])
        );

        assign cin.en   = ch_en[i];
        assign cin.good = good_s[i];

        pgr_channel #(
            .FILT_TICKS (FILT_TICKS),
            .DLY_TICKS  (DLY_TICKS),
            .CW         (CW)
        ) u_chan (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .cin   (cin),
            .rst_n (rst_n_out[i])
        );
    end
endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] rst_n_out
);
    AST_RESET_ALL_LOW: assert property (@(posedge clk)
        $past(rst) |-> (rst_n_out == '0)); // R1

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_DISABLE_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
            $past(!ch_en[i]) |-> !rst_n_out[i]); // R3

        AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
            $rose(rst_n_out[i]) |-> $past(tick)); // R4

        AST_ASSERT_ON_TICK_OR_DISABLE: assert property (@(posedge clk) disable iff (rst)
            $fell(rst_n_out[i]) |-> ($past(tick) || !ch_en[i])); // R6

        AST_STABLE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
            ($past(!tick) && ch_en[i] && $past(ch_en[i])) |-> $stable(rst_n_out[i])); // R9
    end
endmodule

bind pgood_reset_gen pgr_checker #(.NUM_CH(NUM_CH)) u_pgr_checker (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ch_en     (ch_en),
    .rst_n_out (rst_n_out)
);

// File: tb/pgood_reset_gen_test.sv
module pgood_reset_gen_test;
    localparam int NCH  = 4;
    localparam int FILT = 6;
    localparam int DLY  = 40;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick = 1'b0;
    logic           tick_on = 1'b1;
    logic [1:0]     tick_div = '0;
    logic [NCH-1:0] ch_good = '0;
    logic [NCH-1:0] ch_en = '0;
    logic [NCH-1:0] rst_n_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tick_div <= tick_div + 2'd1;
        tick     <= tick_on && (tick_div == 2'd0);
    end

    pgood_reset_gen #(
        .NUM_CH      (NCH),
        .SYNC_STAGES (2),
        .FILT_TICKS  (FILT),
        .DLY_TICKS   (DLY)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ch_good   (ch_good),
        .ch_en     (ch_en),
        .rst_n_out (rst_n_out)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: rst_n_out actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        wait_cyc(5);
        check("R1 during reset", rst_n_out, 4'b0000);
        rst = 1'b0;
        wait_cyc(2);
        check("R1 after reset", rst_n_out, 4'b0000);
    endtask

    task automatic t_release;
        ch_en   = 4'b0111;
        ch_good = 4'b1111;
        wait_cyc(140);
        check("R4 still held before delay", rst_n_out, 4'b0000);
        wait_cyc(60);
        check("R4 released, R2 disabled ch3 low", rst_n_out, 4'b0111);
    endtask

    task automatic t_short_dip;
        ch_good[0] = 1'b0;
        wait_cyc(12);
        ch_good[0] = 1'b1;
        wait_cyc(50);
        check("R5 short dip ignored", rst_n_out, 4'b0111);
    endtask

    task automatic t_long_dip;
        ch_good[1] = 1'b0;
        wait_cyc(40);
        check("R6 long dip asserts, R8 others unchanged", rst_n_out, 4'b0101);
        ch_good[1] = 1'b1;
    endtask

    task automatic t_restart;
        wait_cyc(100);
        ch_good[1] = 1'b0;
        wait_cyc(8);
        ch_good[1] = 1'b1;
        wait_cyc(100);
        check("R7 delay restarted", rst_n_out, 4'b0101);
        wait_cyc(80);
        check("R7 released after full delay", rst_n_out, 4'b0111);
    endtask

    task automatic t_disable_now;
        ch_en[2] = 1'b0;
        #1;
        check("R3 immediate on disable", rst_n_out, 4'b0011);
        wait_cyc(1);
        ch_en[2] = 1'b1;
        wait_cyc(20);
        check("R3 re-enable waits delay", rst_n_out, 4'b0011);
        wait_cyc(200);
        check("R3 released after re-enable", rst_n_out, 4'b0111);
    endtask

    task automatic t_enable_ch3;
        ch_good[3] = 1'b0;
        ch_en[3]   = 1'b1;
        wait_cyc(200);
        check("R4 enabled channel with bad status stays low", rst_n_out, 4'b0111);
        ch_good[3] = 1'b1;
        wait_cyc(200);
        check("R8 ch3 released alone", rst_n_out, 4'b1111);
    endtask

    task automatic t_no_tick;
        tick_on    = 1'b0;
        ch_good[0] = 1'b0;
        wait_cyc(100);
        check("R9 no ticks, no assert", rst_n_out, 4'b1111);
        tick_on = 1'b1;
        wait_cyc(40);
        check("R9 ticks resume, filter expires", rst_n_out, 4'b1110);
        ch_good[0] = 1'b1;
    endtask

    task automatic t_reset_mid;
        wait_cyc(3);
        rst = 1'b1;
        wait_cyc(2);
        check("R1 reset while running", rst_n_out, 4'b0000);
        rst = 1'b0;
    endtask

    initial begin
        wait_cyc(1);
        t_reset();
        t_release();
        t_short_dip();
        t_long_dip();
        t_restart();
        t_disable_now();
        t_enable_ch3();
        t_no_tick();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule